// File: doc/BRIEF.md
# Enhanced parallel port cycle controller

This block sits between a small host register bus and a bidirectional byte-wide parallel port. It runs address and data transfers in both directions. A host write to the address or data port places the byte on the port bus and then pulls the matching strobe low. A host read first releases the port bus and then pulls the matching strobe low. While the strobe is low and the peripheral holds its wait line low, the block drives the host ready line low, which stretches the host access.

The transfer direction comes from a bit in a control register. The block does not wait for the peripheral before asserting a strobe. The host decides when the transfer ends: when it releases its read or write line, the strobe is released. A cycle counter ends any transfer that stalls too long. On expiry it releases the strobe, raises ready and sets a sticky flag. Software clears that flag by writing a 1 to it.

All host control lines, the wait line and the port data pass through two-flop synchronizers. The strobes, the write-direction line and ready are driven straight from flops.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset both strobes are high, ready is high, the write-direction line is low, the port bus is driven and the time-out flag reads 0.
- R2: Control register at select 2, bit 0, is the direction bit. A 0 drives the write-direction line low and enables the port bus drivers. A 1 drives the line high and releases the bus. Reading select 2 returns the bit, and the bit does not change while a strobe is low.
- R3: A host write to select 3 (address) or select 4 (data) with direction 0 drives the host byte onto the port bus. One cycle later it lowers the address strobe for select 3 or the data strobe for select 4. The byte stays on the bus, unchanged, while the strobe is low.
- R4: A host read from select 3 or 4 with direction 1 lowers the matching strobe. The port bus stays released during the strobe.
- R5: The two strobes are never low together.
- R6: Ready is low exactly while a strobe is low and the synchronized wait line is low. It is never low outside a strobe.
- R7: During a read strobe, port data is captured while the synchronized wait line is high. The captured byte is returned on the host bus, with the host output enable high, while the host read line is low on select 3 or 4.
- R8: The strobe is released once the host releases its read or write line. No new transfer starts until the host has released it.
- R9: If the wait line is still low when a strobe has been low for TMO_CYC cycles, the strobe is released, ready goes high and the time-out flag (select 1, bit 1) is set. Select 1, bit 0, reads the synchronized wait line.
- R10: Writing select 1 with bit 1 set clears the time-out flag. Writing it with bit 1 clear leaves the flag unchanged.
- R11: A host write to select 3 or 4 while the direction bit is 1 is ignored, and so is a host read from select 3 or 4 while it is 0. Neither lowers a strobe or ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | AW | Host register select |
| bus_rd_ni | input | 1 | Host read, active low |
| bus_wr_ni | input | 1 | Host write, active low |
| bus_d_i | input | DW | Host write data |
| bus_d_o | output | DW | Host read data |
| bus_d_oe_o | output | 1 | Host read data enable |
| bus_rdy_o | output | 1 | Host ready, low stretches the access |
| prt_d_i | input | DW | Port data from peripheral |
| prt_d_o | output | DW | Port data to peripheral |
| prt_d_oe_o | output | 1 | Port data driver enable |
| prt_wr_no | output | 1 | Transfer direction, low means host writes |
| prt_astb_no | output | 1 | Address strobe, active low |
| prt_dstb_no | output | 1 | Data strobe, active low |
| prt_wait_ni | input | 1 | Peripheral wait, low holds off the transfer |

## Verification
A sequencer stuck in its strobe state shows up within a few cycles of the peripheral raising wait: ready stays low, and both the strobe and ready outlive the host release, so the bench's release wait loops expire. A wrong latched byte or select appears on the port bus or on the wrong strobe at the first transfer of the sweep that uses it. A miscounted timer shows as a strobe whose length differs from TMO_CYC. A flag that is wrongly cleared, or stays set, shows at the next status read.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STRB,
    ST_HOLD
  } epp_st_e;

  localparam logic [2:0] SEL_STAT = 3'd1;
  localparam logic [2:0] SEL_CTRL = 3'd2;
  localparam logic [2:0] SEL_ADDR = 3'd3;
  localparam logic [2:0] SEL_DATA = 3'd4;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/epp_tmo.sv
module epp_tmo #(
  parameter int unsigned CYC = 500,
  localparam int unsigned CW = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic stall_i,
  output logic expire_o
);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  // saturates so a late stall still expires
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && stall_i && (cnt_q == LAST);
endmodule

// File: rtl/epp_regs.sv
module epp_regs
  import epp_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] sel_i,
  input  logic          dir_bit_i,
  input  logic          clr_bit_i,
  input  logic          tmo_set_i,
  input  logic          wait_i,
  input  logic [DW-1:0] hold_i,
  output logic          dir_o,
  output logic          tmo_o,
  output logic [DW-1:0] rdata_o
);
  logic dir_q, tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= 1'b0;
    else if (wr_en_i && sel_i == AW'(SEL_CTRL)) dir_q <= dir_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmo_q <= 1'b0;
    else if (tmo_set_i) tmo_q <= 1'b1;
    else if (wr_en_i && sel_i == AW'(SEL_STAT) && clr_bit_i) tmo_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      AW'(SEL_STAT): rdata_o[1:0] = {tmo_q, wait_i};
      AW'(SEL_CTRL): rdata_o[0]   = dir_q;
      AW'(SEL_ADDR),
      AW'(SEL_DATA): rdata_o      = hold_i;
      default:       rdata_o      = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign tmo_o = tmo_q;
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 3,
  parameter int unsigned TMO_CYC = 500,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_sel_i,
  input  logic          bus_rd_ni,
  input  logic          bus_wr_ni,
  input  logic [DW-1:0] bus_d_i,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_d_oe_o,
  output logic          bus_rdy_o,
  input  logic [DW-1:0] prt_d_i,
  output logic [DW-1:0] prt_d_o,
  output logic          prt_d_oe_o,
  output logic          prt_wr_no,
  output logic          prt_astb_no,
  output logic          prt_dstb_no,
  input  logic          prt_wait_ni
);
  logic [2:0]    ctl_s;
  logic          hrd_s, hwr_s, wait_s;
  logic [DW-1:0] pd_s;

  epp_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b111)) u_sync_ctl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bus_rd_ni, bus_wr_ni, prt_wait_ni}),
    .q_o   (ctl_s)
  );

  epp_sync #(.W(DW), .STAGES(SYNC_N), .RST_VAL('0)) u_sync_dat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (prt_d_i),
    .q_o   (pd_s)
  );

  assign {hrd_s, hwr_s, wait_s} = ctl_s;

  epp_st_e       st_q, st_d;
  logic          is_addr_q, is_addr_d;
  logic          is_rd_q, is_rd_d;
  logic [DW-1:0] out_q, out_d;
  logic [DW-1:0] hold_q;
  logic          astb_nq, dstb_nq, rdy_q;
  logic          tmo_exp, dir, tmo_flag, reg_wr_en, port_sel, sel_ok;
  logic [DW-1:0] rdata;

  assign port_sel = (bus_sel_i == AW'(SEL_ADDR)) || (bus_sel_i == AW'(SEL_DATA));
  assign sel_ok   = port_sel || (bus_sel_i == AW'(SEL_STAT)) || (bus_sel_i == AW'(SEL_CTRL));

  epp_tmo #(.CYC(TMO_CYC)) u_tmo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (st_q == ST_STRB),
    .stall_i (!wait_s),
    .expire_o(tmo_exp)
  );

  always_comb begin
    st_d      = st_q;
    is_addr_d = is_addr_q;
    is_rd_d   = is_rd_q;
    out_d     = out_q;
    unique case (st_q)
      ST_IDLE: begin
        if (!hwr_s && port_sel && !dir) begin
          st_d      = ST_SETUP;
          is_rd_d   = 1'b0;
          is_addr_d = (bus_sel_i == AW'(SEL_ADDR));
          out_d     = bus_d_i;
        end else if (!hrd_s && port_sel && dir) begin
          st_d      = ST_SETUP;
          is_rd_d   = 1'b1;
          is_addr_d = (bus_sel_i == AW'(SEL_ADDR));
        end
      end
      ST_SETUP: st_d = ST_STRB;
      ST_STRB: begin
        if (tmo_exp)                        st_d = ST_HOLD;
        else if (is_rd_q ? hrd_s : hwr_s)   st_d = ST_IDLE;
      end
      ST_HOLD: if (hrd_s && hwr_s) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      is_addr_q <= 1'b0;
      is_rd_q   <= 1'b0;
      out_q     <= '0;
      astb_nq   <= 1'b1;
      dstb_nq   <= 1'b1;
      rdy_q     <= 1'b1;
    end else begin
      st_q      <= st_d;
      is_addr_q <= is_addr_d;
      is_rd_q   <= is_rd_d;
      out_q     <= out_d;
      astb_nq   <= !(st_d == ST_STRB && is_addr_d);
      dstb_nq   <= !(st_d == ST_STRB && !is_addr_d);
      rdy_q     <= !(st_d == ST_STRB && !wait_s);
    end
  end

  // read data follows the port while the peripheral signals ready
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (st_q == ST_STRB && is_rd_q && wait_s) hold_q <= pd_s;
  end

  assign reg_wr_en = (st_q == ST_IDLE) && !hwr_s;

  epp_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (reg_wr_en),
    .sel_i    (bus_sel_i),
    .dir_bit_i(bus_d_i[0]),
    .clr_bit_i(bus_d_i[1]),
    .tmo_set_i(tmo_exp),
    .wait_i   (wait_s),
    .hold_i   (hold_q),
    .dir_o    (dir),
    .tmo_o    (tmo_flag),
    .rdata_o  (rdata)
  );

  assign bus_d_o     = rdata;
  assign bus_d_oe_o  = !hrd_s && sel_ok;
  assign bus_rdy_o   = rdy_q;
  assign prt_d_o     = out_q;
  assign prt_d_oe_o  = !dir;
  assign prt_wr_no   = dir;
  assign prt_astb_no = astb_nq;
  assign prt_dstb_no = dstb_nq;
endmodule

// File: rtl/epp_cycle_chk.sv
module epp_cycle_chk #(
  parameter int unsigned DW      = 8,
  parameter int unsigned TMO_CYC = 500
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          prt_astb_no,
  input logic          prt_dstb_no,
  input logic          prt_wr_no,
  input logic          prt_d_oe_o,
  input logic [DW-1:0] prt_d_o,
  input logic          bus_rdy_o,
  input logic          wait_s
);
  logic stb;
  int unsigned stall_run;
  assign stb = !prt_astb_no || !prt_dstb_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             stall_run <= 0;
    else if (stb && !wait_s) stall_run <= stall_run + 1;
    else                     stall_run <= 0;
  end

  // R5
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!prt_astb_no && !prt_dstb_no));
  // R3
  wr_bus_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && !prt_wr_no) |-> prt_d_oe_o);
  // R3
  wr_byte_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && $past(stb)) |-> $stable(prt_d_o));
  // R4
  rd_bus_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && prt_wr_no) |-> !prt_d_oe_o);
  // R6
  rdy_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rdy_o |-> stb);
  // R2
  dir_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && $past(stb)) |-> $stable(prt_wr_no));
  // R9
  tmo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_run <= TMO_CYC);
endmodule

bind epp_cycle_ctrl epp_cycle_chk #(.DW(DW), .TMO_CYC(TMO_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .prt_astb_no(prt_astb_no),
  .prt_dstb_no(prt_dstb_no),
  .prt_wr_no  (prt_wr_no),
  .prt_d_oe_o (prt_d_oe_o),
  .prt_d_o    (prt_d_o),
  .bus_rdy_o  (bus_rdy_o),
  .wait_s     (wait_s)
);

// File: tb/tb_epp_cycle_ctrl.sv
module tb_epp_cycle_ctrl;
  localparam int DW  = 8;
  localparam int AW  = 3;
  localparam int TMO = 24;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] sel = '0;
  logic rd_n = 1, wr_n = 1, wait_n = 0;
  logic [DW-1:0] hd = '0, pd_in = '0;
  logic [DW-1:0] bus_q, pd_out;
  logic bus_oe, rdy, pd_oe, pwr_n, astb_n, dstb_n;

  always #5 clk = ~clk;

  epp_cycle_ctrl #(.DW(DW), .AW(AW), .TMO_CYC(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_rd_ni(rd_n), .bus_wr_ni(wr_n),
    .bus_d_i(hd), .bus_d_o(bus_q), .bus_d_oe_o(bus_oe), .bus_rdy_o(rdy),
    .prt_d_i(pd_in), .prt_d_o(pd_out), .prt_d_oe_o(pd_oe), .prt_wr_no(pwr_n),
    .prt_astb_no(astb_n), .prt_dstb_no(dstb_n), .prt_wait_ni(wait_n)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // peripheral model
  logic [DW-1:0] per_val = '0, seen_byte = '0;
  bit seen_addr = 0, seen_wr_n = 0, seen_oe = 0, per_never = 0;
  int per_stall = 0;
  int low_cnt = 0, last_len = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (!astb_n || !dstb_n) begin
        seen_addr = !astb_n;
        seen_byte = pd_out;
        seen_wr_n = pwr_n;
        seen_oe   = pd_oe;
        pd_in     = per_val;
        if (!per_never) begin
          repeat (per_stall) @(negedge clk);
          wait_n = 1;
        end
        while (!astb_n || !dstb_n) @(negedge clk);
        wait_n = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!astb_n || !dstb_n) low_cnt <= low_cnt + 1;
    else if (low_cnt != 0) begin
      last_len <= low_cnt;
      low_cnt  <= 0;
    end
  end

  task automatic wait_rdy();
    for (int g = 0; g < 4000 && !rdy; g++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 4000 && (!astb_n || !dstb_n); g++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic port_wr(input logic [AW-1:0] s, input logic [DW-1:0] v);
    @(negedge clk);
    sel = s; hd = v; wr_n = 0;
    repeat (6) @(negedge clk);
    // R6: ready held low at least until the wait line propagates
    chk(rdy == 0, "R6 rdy low in stall", rdy, 0);
    wait_rdy();
    // R3 R5
    chk(seen_byte == v, "R3 port byte", seen_byte, v);
    chk(seen_addr == (s == 3'd3), "R5 strobe select", seen_addr, s == 3'd3);
    chk(seen_wr_n == 0 && seen_oe == 1, "R3 write direction", {seen_wr_n, seen_oe}, 1);
    wr_n = 1;
    wait_idle();
    // R8
    chk(astb_n && dstb_n && rdy, "R8 released", {astb_n, dstb_n, rdy}, 7);
  endtask

  task automatic port_rd(input logic [AW-1:0] s, input logic [DW-1:0] v);
    @(negedge clk);
    per_val = v; sel = s; rd_n = 0;
    repeat (6) @(negedge clk);
    wait_rdy();
    repeat (2) @(negedge clk);
    // R7 R4
    chk(bus_q == v && bus_oe, "R7 read data", {bus_oe, bus_q}, {1'b1, v});
    chk(seen_addr == (s == 3'd3), "R5 strobe select", seen_addr, s == 3'd3);
    chk(seen_wr_n == 1 && seen_oe == 0, "R4 bus released", {seen_wr_n, seen_oe}, 2);
    rd_n = 1;
    wait_idle();
    chk(astb_n && dstb_n && !bus_oe, "R8 read released", {astb_n, dstb_n, bus_oe}, 6);
  endtask

  task automatic reg_wr(input logic [AW-1:0] s, input logic [DW-1:0] v);
    @(negedge clk);
    sel = s; hd = v; wr_n = 0;
    repeat (5) @(negedge clk);
    wr_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic reg_rd(input logic [AW-1:0] s, output logic [DW-1:0] v);
    @(negedge clk);
    sel = s; rd_n = 0;
    repeat (5) @(negedge clk);
    v = bus_q;
    rd_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1
    chk(astb_n && dstb_n && rdy, "R1 idle lines", {astb_n, dstb_n, rdy}, 7);
    chk(pwr_n == 0 && pd_oe == 1, "R1 write mode", {pwr_n, pd_oe}, 1);
    reg_rd(3'd1, r);
    chk(r[1] == 0, "R1 flag clear", r[1], 0);

    // R3 sweep, address and data ports, varied stall
    for (int v = 0; v < 256; v++) begin
      per_stall = v % 7;
      port_wr(3'd3, DW'(v));
      port_wr(3'd4, DW'(v ^ 8'h5a));
    end

    // R11: read while in write mode
    @(negedge clk); sel = 3'd4; rd_n = 0;
    repeat (10) @(negedge clk);
    chk(astb_n && dstb_n && rdy, "R11 read ignored", {astb_n, dstb_n, rdy}, 7);
    rd_n = 1; repeat (4) @(negedge clk);

    // R2
    reg_wr(3'd2, 8'h01);
    chk(pwr_n == 1 && pd_oe == 0, "R2 read mode", {pwr_n, pd_oe}, 2);
    reg_rd(3'd2, r);
    chk(r[0] == 1, "R2 readback", r[0], 1);

    // R11: write while in read mode
    @(negedge clk); sel = 3'd3; hd = 8'hff; wr_n = 0;
    repeat (10) @(negedge clk);
    chk(astb_n && dstb_n && rdy, "R11 write ignored", {astb_n, dstb_n, rdy}, 7);
    wr_n = 1; repeat (4) @(negedge clk);

    // R4 R7 sweep
    for (int v = 0; v < 256; v++) begin
      per_stall = (v * 3) % 5;
      port_rd(3'd4, DW'(v ^ 8'h3c));
      port_rd(3'd3, DW'(255 - v));
    end

    // R9 time-out in write mode
    reg_wr(3'd2, 8'h00);
    chk(pwr_n == 0 && pd_oe == 1, "R2 back to write", {pwr_n, pd_oe}, 1);
    per_never = 1;
    @(negedge clk); sel = 3'd4; hd = 8'h77; wr_n = 0;
    repeat (6) @(negedge clk);
    wait_rdy();
    repeat (2) @(negedge clk);
    chk(astb_n && dstb_n && rdy, "R9 released on expiry", {astb_n, dstb_n, rdy}, 7);
    chk(last_len == TMO, "R9 strobe length", last_len, TMO);
    wr_n = 1; repeat (4) @(negedge clk);
    per_never = 0;
    reg_rd(3'd1, r);
    chk(r[1:0] == 2'b10, "R9 status flag", r[1:0], 2);

    // R10
    reg_wr(3'd1, 8'hfd);
    reg_rd(3'd1, r);
    chk(r[1] == 1, "R10 zero keeps flag", r[1], 1);
    reg_wr(3'd1, 8'h02);
    reg_rd(3'd1, r);
    chk(r[1] == 0, "R10 one clears flag", r[1], 0);

    // R8: transfer still works after time-out
    per_stall = 2;
    port_wr(3'd3, 8'hc3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule